// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block takes one power partition of a chip from off to running. A single-cycle request carries the partition index. The block then works through a fixed series of steps. It holds the partition in reset and stops its clock before it applies power. Once power is confirmed it restarts the clock and waits a timed settle interval. It then releases the isolation clamps and takes the partition out of reset. Every step raises a request output and waits for the matching acknowledge from the power switch, clock generator, clamp cells or reset logic outside the block. Each wait has a timeout, counted in microsecond ticks from a prescaler on the system clock.

When a step fails, the block rolls back. What it undoes depends on how far the sequence got. A failure at clamp release or at reset release first turns the clock off, then asserts reset, then powers the partition down. A failure while stopping the clock, applying power or enabling the clock leaves the clock request alone, asserts reset and powers the partition down. At the end the block pulses `done`, and it pulses `error` in the same cycle if the sequence failed. The request outputs keep their final levels until the next request.

Top module: `part_pwr_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `error`, `pwr_toggle` and `clamp_rel` are 0, `rst_req` is 0, `clk_req` is 1 and `part_sel` is 0.
- R2: A `req_valid` pulse while idle copies `req_part` to `part_sel` and raises `busy`. The first action is to raise `rst_req`, and the block then waits for `rst_ack` to go high.
- R3: A clean run produces the output events in this order: `rst_req` rises (code 1), `clk_req` falls (code 2), `pwr_toggle` pulses (code 3), `clk_req` rises (code 4), `clamp_rel` rises (code 5), `rst_req` falls (code 6). The run then ends with `done`=1 and `error`=0.
- R4: If bit `part_sel` of `pwr_state` is already 1 when the power step begins, no `pwr_toggle` pulse is issued and the sequence goes straight on to clock enable.
- R5: After `clk_ack` rises in the clock-enable step, `clamp_rel` rises SETTLE_US*CYC_PER_US+2 cycles later, within one cycle.
- R6: A wait whose acknowledge never arrives is abandoned POLL_US*CYC_PER_US+1 cycles after the wait begins, within one cycle.
- R7: A failure at clamp release or at reset release rolls back in this order: `clk_req` falls, `rst_req` is raised, and the partition is toggled off. The run ends with `error`=1.
- R8: A failure at clock stop, power-on or clock enable leaves `clk_req` unchanged. The rollback raises `rst_req` and toggles the partition off only if `pwr_state[part_sel]` is 1. The run ends with `error`=1.
- R9: If `rst_ack` never rises after reset is requested, the run ends with `done`=1 and `error`=1. No clock, power or clamp action takes place.
- R10: While `busy` is 1, `req_valid` is ignored: `part_sel` does not change and no second run follows.
- R11: `done` is high for exactly one cycle per run, and `error` is high only together with `done`. After `done`, `busy` is 0 and `rst_req` and `clk_req` hold their final levels.
- R12: `pwr_toggle` is a one-cycle pulse and occurs only while `rst_req` is 1. `clamp_rel` is 1 only while `clk_req` and `rst_req` are both 1. Only bit `part_sel` of `pwr_state` is consulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start pulse, accepted only while idle |
| req_part | input | IDX_W | Index of the partition to bring up |
| pwr_state | input | N_PART | Present power state of each partition, 1 = on |
| rst_ack | input | 1 | Reset of the selected partition is asserted |
| clk_ack | input | 1 | Clock of the selected partition is running |
| clamp_ack | input | 1 | Clamps of the selected partition are released |
| part_sel | output | IDX_W | Partition being sequenced |
| rst_req | output | 1 | Request partition reset asserted |
| clk_req | output | 1 | Request partition clock running |
| pwr_toggle | output | 1 | One-cycle request to flip partition power |
| clamp_rel | output | 1 | Request clamp release |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | With done: the run failed and was rolled back |

## Verification
A wrong state in the sequencer shows up at the outputs as a misplaced or missing request edge. The bench logs every edge as a code and compares the whole trace against the order the requirements predict for each injected failure point. A timer or prescaler error moves the clamp-release edge or the abandon edge by at least one cycle. The bench measures both edges against the acknowledge that starts them. A wrong rollback stage leaves `clk_req`, `rst_req` or the modelled power bit at the wrong final level, and the bench checks these in the cycle that `done` appears.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_ON,
    S_CLK_STOP,
    S_PWR_ON,
    S_PWR_WAIT,
    S_CLK_ON,
    S_SETTLE,
    S_CLAMP,
    S_RST_OFF,
    S_RB_CLK,
    S_RB_RST,
    S_RB_PWR,
    S_RB_PWR_WAIT,
    S_FIN_OK,
    S_FIN_ERR
  } pps_state_e;
endpackage

// File: rtl/pps_us_timer.sv
// Microsecond tick prescaler and a saturating tick counter. Both are
// cleared by restart, so every wait starts on a whole interval.
module pps_us_timer #(
  parameter int CYC_PER_US = 4,
  parameter int CNT_MAX    = 100,
  parameter int CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

  logic tick;

  generate
    if (CYC_PER_US == 1) begin : g_nopre
      assign tick = 1'b1;
    end else begin : g_pre
      logic [PRE_W-1:0] pre;
      assign tick = (pre == PRE_W'(CYC_PER_US - 1));
      always_ff @(posedge clk) begin
        if (rst || restart) pre <= '0;
        else if (tick)      pre <= '0;
        else                pre <= pre + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || restart)                     cnt <= '0;
    else if (tick && cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pps_stat_sel.sv
// Picks the power state bit of the partition being sequenced.
module pps_stat_sel #(
  parameter int N_PART = 8,
  parameter int IDX_W  = (N_PART > 1) ? $clog2(N_PART) : 1
) (
  input  logic [N_PART-1:0] pwr_state,
  input  logic [IDX_W-1:0]  sel,
  output logic              on
);
  always_comb begin
    on = 1'b0;
    for (int i = 0; i < N_PART; i++)
      if (sel == IDX_W'(i)) on = pwr_state[i];
  end
endmodule

// File: rtl/pps_fsm.sv
// Step sequencer. Outputs are registered from the next state, so each
// request edge appears on the same clock edge as the state change.
module pps_fsm
  import pps_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 7,
  parameter int POLL_US   = 100,
  parameter int SETTLE_US = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_part,
  input  logic             pwr_on,
  input  logic             rst_ack,
  input  logic             clk_ack,
  input  logic             clamp_ack,
  input  logic [CNT_W-1:0] us_cnt,
  output logic             restart,
  output logic [IDX_W-1:0] part_sel,
  output logic             rst_req,
  output logic             clk_req,
  output logic             pwr_toggle,
  output logic             clamp_rel,
  output logic             busy,
  output logic             done,
  output logic             error
);
  pps_state_e st, nxt;
  logic poll_exp, settle_exp;

  assign poll_exp   = (us_cnt >= CNT_W'(POLL_US));
  assign settle_exp = (us_cnt >= CNT_W'(SETTLE_US));
  assign restart    = (nxt != st);

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:        if (req_valid) nxt = S_RST_ON;
      S_RST_ON:      if (rst_ack) nxt = S_CLK_STOP;
                     else if (poll_exp) nxt = S_FIN_ERR;
      S_CLK_STOP:    if (!clk_ack) nxt = S_PWR_ON;
                     else if (poll_exp) nxt = S_RB_RST;
      S_PWR_ON:      nxt = pwr_on ? S_CLK_ON : S_PWR_WAIT;
      S_PWR_WAIT:    if (pwr_on) nxt = S_CLK_ON;
                     else if (poll_exp) nxt = S_RB_RST;
      S_CLK_ON:      if (clk_ack) nxt = S_SETTLE;
                     else if (poll_exp) nxt = S_RB_RST;
      S_SETTLE:      if (settle_exp) nxt = S_CLAMP;
      S_CLAMP:       if (clamp_ack) nxt = S_RST_OFF;
                     else if (poll_exp) nxt = S_RB_CLK;
      S_RST_OFF:     if (!rst_ack) nxt = S_FIN_OK;
                     else if (poll_exp) nxt = S_RB_CLK;
      S_RB_CLK:      if (!clk_ack || poll_exp) nxt = S_RB_RST;
      S_RB_RST:      if (rst_ack || poll_exp) nxt = S_RB_PWR;
      S_RB_PWR:      nxt = pwr_on ? S_RB_PWR_WAIT : S_FIN_ERR;
      S_RB_PWR_WAIT: if (!pwr_on || poll_exp) nxt = S_FIN_ERR;
      S_FIN_OK:      nxt = S_IDLE;
      S_FIN_ERR:     nxt = S_IDLE;
      default:       nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      part_sel   <= '0;
      rst_req    <= 1'b0;
      clk_req    <= 1'b1;
      pwr_toggle <= 1'b0;
      clamp_rel  <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && req_valid) part_sel <= req_part;
      if (nxt == S_RST_ON || nxt == S_RB_RST) rst_req <= 1'b1;
      else if (nxt == S_RST_OFF)              rst_req <= 1'b0;
      if (nxt == S_CLK_STOP || nxt == S_RB_CLK) clk_req <= 1'b0;
      else if (nxt == S_CLK_ON)                 clk_req <= 1'b1;
      pwr_toggle <= (nxt == S_PWR_WAIT && st != S_PWR_WAIT) ||
                    (nxt == S_RB_PWR_WAIT && st != S_RB_PWR_WAIT);
      clamp_rel  <= (nxt == S_CLAMP);
      busy       <= (nxt != S_IDLE);
      done       <= (nxt == S_FIN_OK) || (nxt == S_FIN_ERR);
      error      <= (nxt == S_FIN_ERR);
    end
  end
endmodule

// File: rtl/part_pwr_seq.sv
module part_pwr_seq #(
  parameter int N_PART     = 8,
  parameter int CYC_PER_US = 4,
  parameter int POLL_US    = 100,
  parameter int SETTLE_US  = 20,
  localparam int IDX_W     = (N_PART > 1) ? $clog2(N_PART) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_part,
  input  logic [N_PART-1:0] pwr_state,
  input  logic              rst_ack,
  input  logic              clk_ack,
  input  logic              clamp_ack,
  output logic [IDX_W-1:0]  part_sel,
  output logic              rst_req,
  output logic              clk_req,
  output logic              pwr_toggle,
  output logic              clamp_rel,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int CNT_MAX = (POLL_US > SETTLE_US) ? POLL_US : SETTLE_US;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             restart;
  logic             pwr_on;
  logic [CNT_W-1:0] us_cnt;

  pps_us_timer #(.CYC_PER_US(CYC_PER_US), .CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .restart(restart), .cnt(us_cnt)
  );

  pps_stat_sel #(.N_PART(N_PART), .IDX_W(IDX_W)) i_sel (
    .pwr_state(pwr_state), .sel(part_sel), .on(pwr_on)
  );

  pps_fsm #(.IDX_W(IDX_W), .CNT_W(CNT_W), .POLL_US(POLL_US), .SETTLE_US(SETTLE_US)) i_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_part(req_part),
    .pwr_on(pwr_on), .rst_ack(rst_ack), .clk_ack(clk_ack), .clamp_ack(clamp_ack),
    .us_cnt(us_cnt), .restart(restart), .part_sel(part_sel), .rst_req(rst_req),
    .clk_req(clk_req), .pwr_toggle(pwr_toggle), .clamp_rel(clamp_rel),
    .busy(busy), .done(done), .error(error)
  );
endmodule

// File: rtl/pps_seq_chk.sv
module pps_seq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] part_sel,
  input logic             rst_req,
  input logic             clk_req,
  input logic             pwr_toggle,
  input logic             clamp_rel,
  input logic             busy,
  input logic             done,
  input logic             error
);
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    error |-> done);                                           // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                           // R11
  AST_OK_LEVELS: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> (!rst_req && clk_req));               // R3
  AST_TOGGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pwr_toggle |=> !pwr_toggle);                               // R12
  AST_TOGGLE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    pwr_toggle |-> rst_req);                                   // R12
  AST_CLAMP_SAFE: assert property (@(posedge clk) disable iff (rst)
    clamp_rel |-> (clk_req && rst_req));                       // R12
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(part_sel));              // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!pwr_toggle && !clamp_rel));                    // R2
endmodule

bind part_pwr_seq pps_seq_chk #(.IDX_W(IDX_W)) i_pps_chk (
  .clk(clk), .rst(rst), .part_sel(part_sel), .rst_req(rst_req),
  .clk_req(clk_req), .pwr_toggle(pwr_toggle), .clamp_rel(clamp_rel),
  .busy(busy), .done(done), .error(error)
);

// File: tb/test_part_pwr_seq.sv
`timescale 1ns/1ps
module test_part_pwr_seq;
  localparam int N_PART = 8;
  localparam int CPU    = 4;
  localparam int POLL   = 100;
  localparam int SETL   = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, req_valid = 1'b0;
  logic [2:0] req_part = '0;
  logic [N_PART-1:0] pwr_state;
  logic rst_ack, clk_ack, clamp_ack;
  logic [2:0] part_sel;
  logic rst_req, clk_req, pwr_toggle, clamp_rel, busy, done, error;

  part_pwr_seq #(.N_PART(N_PART), .CYC_PER_US(CPU), .POLL_US(POLL), .SETTLE_US(SETL)) i_part_pwr_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_part(req_part),
    .pwr_state(pwr_state), .rst_ack(rst_ack), .clk_ack(clk_ack), .clamp_ack(clamp_ack),
    .part_sel(part_sel), .rst_req(rst_req), .clk_req(clk_req), .pwr_toggle(pwr_toggle),
    .clamp_rel(clamp_rel), .busy(busy), .done(done), .error(error)
  );

  int checks = 0, errs = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Environment model: acknowledges follow requests after 3 cycles;
  // fail_sel names the step (1..6) whose acknowledge never arrives.
  logic mdl_clr = 1'b1;
  int   fail_sel = 0;
  logic [N_PART-1:0] init_pat = '0;
  logic [2:0] rst_p, clk_p, clamp_p;
  logic [2:0] pend;
  logic [2:0] pend_idx;
  always @(negedge clk) begin
    if (mdl_clr) begin
      rst_p <= '0; rst_ack <= 1'b0; clk_p <= '1; clk_ack <= 1'b1;
      clamp_p <= '0; clamp_ack <= 1'b0; pend <= '0; pend_idx <= '0;
      pwr_state <= init_pat;
    end else begin
      rst_p <= {rst_p[1:0], rst_req};
      if (!(fail_sel == 1 && rst_p[2]) && !(fail_sel == 6 && !rst_p[2])) rst_ack <= rst_p[2];
      clk_p <= {clk_p[1:0], clk_req};
      if (!(fail_sel == 2 && !clk_p[2]) && !(fail_sel == 4 && clk_p[2])) clk_ack <= clk_p[2];
      clamp_p <= {clamp_p[1:0], clamp_rel};
      if (!(fail_sel == 5 && clamp_p[2])) clamp_ack <= clamp_p[2];
      if (pwr_toggle && !(fail_sel == 3 && !pwr_state[part_sel])) begin
        pend <= 3'd3; pend_idx <= part_sel;
      end else if (pend != 0) begin
        pend <= pend - 1'b1;
        if (pend == 3'd1) pwr_state[pend_idx] <= ~pwr_state[pend_idx];
      end
    end
  end

  // Event logger: edge codes 1..6 as stated in R3.
  logic [63:0] sig;
  logic p_rst, p_clk, p_clamp, p_ack;
  int t_ack, t_clamp, t_clkfall, n_done;
  always @(negedge clk) begin
    if (mdl_clr) begin
      sig <= '0; p_rst <= 1'b0; p_clk <= 1'b1; p_clamp <= 1'b0; p_ack <= 1'b1;
      t_ack <= 0; t_clamp <= 0; t_clkfall <= 0; n_done <= 0;
    end else begin
      logic [63:0] s;
      s = sig;
      if (rst_req && !p_rst)     s = {s[59:0], 4'd1};
      if (!clk_req && p_clk)   begin s = {s[59:0], 4'd2}; t_clkfall <= cyc; end
      if (pwr_toggle)            s = {s[59:0], 4'd3};
      if (clk_req && !p_clk)     s = {s[59:0], 4'd4};
      if (clamp_rel && !p_clamp) begin s = {s[59:0], 4'd5}; t_clamp <= cyc; end
      if (!rst_req && p_rst)     s = {s[59:0], 4'd6};
      if (clk_ack && !p_ack)     t_ack <= cyc;
      if (done) n_done <= n_done + 1;
      sig <= s;
      p_rst <= rst_req; p_clk <= clk_req; p_clamp <= clamp_rel; p_ack <= clk_ack;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_sig(int f, bit pre);
    logic [63:0] s;
    s = {60'd0, 4'd1};
    if (f == 1) return s;
    s = {s[59:0], 4'd2};
    if (f == 2) return pre ? {s[59:0], 4'd3} : s;
    if (!pre) s = {s[59:0], 4'd3};
    if (f == 3) return s;
    s = {s[59:0], 4'd4};
    if (f == 4) return {s[59:0], 4'd3};
    s = {s[59:0], 4'd5};
    if (f == 5) return {s[55:0], 4'd2, 4'd3};
    s = {s[59:0], 4'd6};
    if (f == 6) return {s[51:0], 4'd2, 4'd1, 4'd3};
    return s;
  endfunction

  task automatic do_reset(input int f, input logic [N_PART-1:0] pat);
    @(posedge clk); #1;
    rst = 1'b1; mdl_clr = 1'b1; fail_sel = f; init_pat = pat;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0; mdl_clr = 1'b0;
  endtask

  task automatic start(input logic [2:0] p);
    @(posedge clk); #1; req_valid = 1'b1; req_part = p;
    @(posedge clk); #1; req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk); #1;
    while (!done && n < 3000) begin @(negedge clk); #1; n++; end
  endtask

  typedef struct packed { logic [3:0] part; logic [3:0] fail; logic pre; } vec_t;
  localparam vec_t VECS [10] = '{
    '{4'd2, 4'd0, 1'b0}, '{4'd5, 4'd0, 1'b1}, '{4'd1, 4'd1, 1'b0},
    '{4'd3, 4'd2, 1'b0}, '{4'd6, 4'd3, 1'b0}, '{4'd0, 4'd4, 1'b0},
    '{4'd7, 4'd5, 1'b0}, '{4'd4, 4'd6, 1'b0}, '{4'd2, 4'd5, 1'b1},
    '{4'd3, 4'd2, 1'b1}};

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(0, 8'h5A);
    @(negedge clk); #1;
    chk(!busy && !done && !error && !pwr_toggle && !clamp_rel, "R1", "idle flags",
        {busy, done, error, pwr_toggle, clamp_rel}, 0);
    chk(!rst_req && clk_req && part_sel == 0, "R1", "reset levels",
        {rst_req, clk_req, part_sel}, 5'b01000);

    // Table of runs: R3 R4 R7 R8 R9 R11 R12
    for (int i = 0; i < 10; i++) begin
      vec_t v = VECS[i];
      logic [N_PART-1:0] pat, exp_pat;
      bit exp_clk;
      pat = 8'h5A; pat[v.part[2:0]] = v.pre;
      exp_pat = pat; exp_pat[v.part[2:0]] = (v.fail == 0);
      exp_clk = (v.fail == 0 || v.fail == 1 || v.fail == 4);
      do_reset(int'(v.fail), pat);
      start(v.part[2:0]);
      wait_done();
      chk(done && error == (v.fail != 0), "R11", "done/error",
          {done, error}, {1'b1, v.fail != 0});
      chk(sig == exp_sig(int'(v.fail), v.pre), "R3 R4 R7 R8 R9 R12", "event order",
          sig, exp_sig(int'(v.fail), v.pre));
      chk(rst_req == (v.fail != 0) && clk_req == exp_clk, "R7 R8", "final levels",
          {rst_req, clk_req}, {v.fail != 0, exp_clk});
      chk(pwr_state == exp_pat, "R8 R12", "power bits", pwr_state, exp_pat);
      @(negedge clk); #1;
      chk(!done && !error && !busy, "R11", "done single cycle", {done, error, busy}, 0);
    end

    // R5 settle interval
    do_reset(0, 8'h00);
    start(3'd1);
    wait_done();
    chk(t_clamp - t_ack >= SETL*CPU + 1 && t_clamp - t_ack <= SETL*CPU + 3, "R5",
        "settle cycles", t_clamp - t_ack, SETL*CPU + 2);

    // R6 timeout on clamp acknowledge
    do_reset(5, 8'h00);
    start(3'd6);
    wait_done();
    chk(t_clkfall - t_clamp >= POLL*CPU && t_clkfall - t_clamp <= POLL*CPU + 2, "R6",
        "timeout cycles", t_clkfall - t_clamp, POLL*CPU + 1);

    // R2 accept and R10 ignore while busy
    do_reset(0, 8'h00);
    start(3'd4);
    @(negedge clk); #1;
    chk(busy && part_sel == 3'd4 && rst_req, "R2", "accept", {busy, part_sel, rst_req}, 5'b11001);
    repeat (10) @(posedge clk);
    #1; req_valid = 1'b1; req_part = 3'd2;
    @(posedge clk); #1; req_valid = 1'b0;
    @(negedge clk); #1;
    chk(part_sel == 3'd4, "R10", "sel held", part_sel, 4);
    wait_done();
    repeat (5) @(negedge clk);
    #1;
    chk(n_done == 1 && !busy, "R10", "no second run", {n_done[3:0], busy}, 5'b00010);
    chk(pwr_state == 8'h10, "R10", "only one partition", pwr_state, 8'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule